// File: doc/BRIEF.md
# Multi-Mode General-Purpose Timer Bank

This block holds a small bank of general-purpose timers, three by default. Each timer owns one bidirectional pin and runs in one of three modes. In waveform mode it drives a periodic pulse onto the pin. In capture mode it samples the pin and measures pulse width and period. In event mode it counts rising edges on the pin. Each timer has a six-bit configuration word and three counter-wide registers: count, period and width. A periodic interrupt pulse marks period expiry, a completed capture, or a reached event count.

Software reaches every register through a word-addressed bus. A write to the register sits in that register on the next cycle, and reads are combinational on the address. A shared control word starts or stops any subset of the timers in a single write. The same word reports a sticky overflow flag for each timer, which is cleared by writing one to it. A halt input models a debugger stop. A timer freezes while it is asserted unless its configuration allows it to keep running.

Top module: `gp_timer_bank`

## Requirements
- R1: After reset every register reads zero, no pin is driven (`pin_oe` low) and no interrupt is raised.
- R2: Configuration word layout: bits [1:0] select the mode (0 idle, 1 waveform, 2 capture, 3 event), bit 2 inverts the pin, bit 3 enables the interrupt, bit 4 selects the capture interrupt (1 at period latch, 0 at width latch), bit 5 keeps the timer running during halt. Only bits [5:0] are stored and read back. Timer i's configuration, count, period and width sit at word addresses 4i, 4i+1, 4i+2 and 4i+3.
- R3: The shared control word sits at word address 4N. Writing 1 to bit i starts timer i and restarts it: the count goes to zero and the capture logic is disarmed. Writing 1 to bit 8+i stops timer i. A read returns the run state in bits [N-1:0] and the overflow flags in bits [16+N-1:16].
- R4: In waveform mode the pin is driven. Its value is the polarity bit XOR (count < width). While running, the count rises by one each cycle and returns to zero in the cycle after it equals the period, so the waveform repeats every period+1 cycles.
- R5: In waveform mode, with the interrupt enabled, `irq` is high for exactly one cycle, namely the cycle in which the count has just returned to zero.
- R6: In capture mode the pin is synchronized through two flops and XORed with the polarity bit. The first rising edge arms the timer. Each later falling edge latches the high time in cycles into width, and each later rising edge latches the rising-to-rising time into period and restarts the count.
- R7: In capture mode, with the interrupt enabled, `irq` pulses one cycle after the period latch when bit 4 is set, and one cycle after the width latch when it is clear.
- R8: In event mode each synchronized rising edge increments the count. When the incremented value equals the period, the count returns to zero and `irq` pulses one cycle later if enabled.
- R9: A count that wraps from all ones in capture or event mode sets that timer's overflow flag. Writing 1 to its control-word bit clears the flag, and writing 0 leaves it set.
- R10: While `emu_halt` is high, a running timer whose bit 5 is clear holds its count. With bit 5 set it keeps counting.
- R11: A stopped timer holds its count. In a mode other than waveform its pin is not driven.
- R12: Software writes to count, period and width read back on the next cycle and take priority over hardware updates in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| emu_halt | input | 1 | Debugger halt request |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW (4) | Word address |
| bus_wdata | input | CW (32) | Write data |
| bus_rdata | output | CW (32) | Read data for `bus_addr` |
| pin_i | input | N (3) | Pin input level, one bit per timer |
| pin_o | output | N (3) | Pin output level, one bit per timer |
| pin_oe | output | N (3) | Pin output enable, one bit per timer |
| irq | output | N (3) | One-cycle interrupt pulse, one bit per timer |

## Verification
Most internal errors show up at the pins within one period. A count that drifts changes the duty cycle or the spacing of the waveform interrupt within period+1 cycles. A wrong arming state after a restart appears as a spurious or missing capture interrupt at the second pin edge. A lost halt or enable state shows up either as moving pins while frozen or as a count readback that differs on the very next read. Flaws in the latched width and period values, and in the overflow flag, stay hidden until software reads them, so the bench reads those registers back at the points where they are expected to change.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

  localparam int CFG_W = 6;

  typedef enum logic [1:0] {
    GPT_IDLE = 2'd0,
    GPT_PWM  = 2'd1,
    GPT_CAP  = 2'd2,
    GPT_EVT  = 2'd3
  } gpt_mode_e;

  // bit 5 .. bit 0
  typedef struct packed {
    logic      emu_run;
    logic      cap_per_irq;
    logic      irq_en;
    logic      pol;
    gpt_mode_e mode;
  } gpt_cfg_t;

endpackage

// File: rtl/gpt_edge.sv
module gpt_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic pol,
  output logic rise,
  output logic fall
);

  logic s1_q, s2_q, prev_q;
  logic lvl_now, lvl_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  always_comb begin
    lvl_now  = s2_q ^ pol;
    lvl_prev = prev_q ^ pol;
    rise     = lvl_now & ~lvl_prev;
    fall     = ~lvl_now & lvl_prev;
  end

endmodule

// File: rtl/gpt_core.sv
module gpt_core
  import gpt_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  gpt_cfg_t      cfg,
  input  logic          en,
  input  logic          halt,
  input  logic          restart,
  input  logic          rise,
  input  logic          fall,
  input  logic          cnt_we,
  input  logic          per_we,
  input  logic          wid_we,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] per_q,
  output logic [CW-1:0] wid_q,
  output logic          pin_o,
  output logic          pin_oe,
  output logic          irq_q,
  output logic          ovf_evt
);

  logic [CW-1:0] cnt_n, per_n, wid_n, cnt_inc;
  logic          armed_q, armed_n;
  logic          run, cnt_max, evt, irq_n;

  always_comb begin
    cnt_n   = cnt_q;
    per_n   = per_q;
    wid_n   = wid_q;
    armed_n = armed_q;
    evt     = 1'b0;
    ovf_evt = 1'b0;
    run     = en & (~halt | cfg.emu_run);
    cnt_inc = cnt_q + CW'(1);
    cnt_max = &cnt_q;

    unique case (cfg.mode)
      GPT_PWM: begin
        if (run) begin
          if (cnt_q == per_q) begin
            cnt_n = '0;
            evt   = 1'b1;
          end else begin
            cnt_n = cnt_inc;
          end
        end
      end
      GPT_CAP: begin
        if (run) begin
          if (armed_q) begin
            cnt_n   = cnt_inc;
            ovf_evt = cnt_max;
          end
          if (rise) begin
            if (armed_q) begin
              per_n = cnt_inc;
              evt   = cfg.cap_per_irq;
            end
            cnt_n   = '0;
            ovf_evt = 1'b0;
            armed_n = 1'b1;
          end else if (fall && armed_q) begin
            wid_n = cnt_inc;
            evt   = ~cfg.cap_per_irq;
          end
        end
      end
      GPT_EVT: begin
        if (run && rise) begin
          cnt_n   = cnt_inc;
          ovf_evt = cnt_max;
          if (cnt_inc == per_q) begin
            cnt_n = '0;
            evt   = 1'b1;
          end
        end
      end
      default: ;
    endcase

    if (restart) begin
      cnt_n   = '0;
      armed_n = 1'b0;
    end
    if (cnt_we) cnt_n = wdata;
    if (per_we) per_n = wdata;
    if (wid_we) wid_n = wdata;

    irq_n = evt & cfg.irq_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      per_q   <= '0;
      wid_q   <= '0;
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      per_q   <= per_n;
      wid_q   <= wid_n;
      armed_q <= armed_n;
      irq_q   <= irq_n;
    end
  end

  always_comb begin
    pin_oe = (cfg.mode == GPT_PWM);
    pin_o  = cfg.pol ^ (pin_oe & en & (cnt_q < wid_q));
  end

endmodule

// File: rtl/gpt_regs.sv
module gpt_regs
  import gpt_pkg::*;
#(
  parameter int N  = 3,
  parameter int CW = 32,
  parameter int AW = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_we,
  input  logic [AW-1:0]         bus_addr,
  input  logic [CW-1:0]         bus_wdata,
  output logic [CW-1:0]         bus_rdata,
  input  logic [N-1:0][CW-1:0]  cnt,
  input  logic [N-1:0][CW-1:0]  per,
  input  logic [N-1:0][CW-1:0]  wid,
  input  logic [N-1:0]          ovf_evt,
  output gpt_cfg_t [N-1:0]      cfg_q,
  output logic [N-1:0]          en_q,
  output logic [N-1:0]          ovf_q,
  output logic [N-1:0]          restart,
  output logic [N-1:0]          cnt_we,
  output logic [N-1:0]          per_we,
  output logic [N-1:0]          wid_we
);

  localparam int IW = AW - 2;
  localparam logic [AW-1:0] CTRL_A = AW'(4 * N);

  gpt_cfg_t [N-1:0] cfg_n;
  logic [N-1:0]     en_n, ovf_n, cfg_we;
  logic             ctrl_we;

  always_comb begin
    ctrl_we = bus_we && (bus_addr == CTRL_A);
    for (int i = 0; i < N; i++) begin
      cfg_we[i]  = bus_we && (bus_addr[AW-1:2] == IW'(i)) && (bus_addr[1:0] == 2'd0);
      cnt_we[i]  = bus_we && (bus_addr[AW-1:2] == IW'(i)) && (bus_addr[1:0] == 2'd1);
      per_we[i]  = bus_we && (bus_addr[AW-1:2] == IW'(i)) && (bus_addr[1:0] == 2'd2);
      wid_we[i]  = bus_we && (bus_addr[AW-1:2] == IW'(i)) && (bus_addr[1:0] == 2'd3);
      restart[i] = ctrl_we && bus_wdata[i];
      cfg_n[i]   = cfg_we[i] ? gpt_cfg_t'(bus_wdata[CFG_W-1:0]) : cfg_q[i];
    end
    en_n  = ctrl_we ? ((en_q | bus_wdata[N-1:0]) & ~bus_wdata[8 +: N]) : en_q;
    ovf_n = (ovf_q & ~(ctrl_we ? bus_wdata[16 +: N] : {N{1'b0}})) | ovf_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      en_q  <= '0;
      ovf_q <= '0;
    end else begin
      cfg_q <= cfg_n;
      en_q  <= en_n;
      ovf_q <= ovf_n;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CTRL_A) begin
      bus_rdata[N-1:0]   = en_q;
      bus_rdata[16 +: N] = ovf_q;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (bus_addr[AW-1:2] == IW'(i)) begin
          unique case (bus_addr[1:0])
            2'd0:    bus_rdata = CW'(cfg_q[i]);
            2'd1:    bus_rdata = cnt[i];
            2'd2:    bus_rdata = per[i];
            default: bus_rdata = wid[i];
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/gp_timer_bank.sv
module gp_timer_bank
  import gpt_pkg::*;
#(
  parameter int N  = 3,
  parameter int CW = 32,
  parameter int AW = $clog2(4 * N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          emu_halt,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  input  logic [N-1:0]  pin_i,
  output logic [N-1:0]  pin_o,
  output logic [N-1:0]  pin_oe,
  output logic [N-1:0]  irq
);

  logic [1:0]            rst_sync_q;
  logic                  rst_sync_n;
  gpt_cfg_t [N-1:0]      cfg_q;
  logic [N-1:0]          en_q, ovf_st, ovf_evt, restart, cnt_we, per_we, wid_we;
  logic [N-1:0]          rise, fall;
  logic [N-1:0][CW-1:0]  cnt_q, per_q, wid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  gpt_regs #(.N(N), .CW(CW), .AW(AW)) regs_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cnt       (cnt_q),
    .per       (per_q),
    .wid       (wid_q),
    .ovf_evt   (ovf_evt),
    .cfg_q     (cfg_q),
    .en_q      (en_q),
    .ovf_q     (ovf_st),
    .restart   (restart),
    .cnt_we    (cnt_we),
    .per_we    (per_we),
    .wid_we    (wid_we)
  );

  for (genvar g = 0; g < N; g++) begin : g_tmr
    gpt_edge edge_i (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .pin_i (pin_i[g]),
      .pol   (cfg_q[g].pol),
      .rise  (rise[g]),
      .fall  (fall[g])
    );

    gpt_core #(.CW(CW)) core_i (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .cfg     (cfg_q[g]),
      .en      (en_q[g]),
      .halt    (emu_halt),
      .restart (restart[g]),
      .rise    (rise[g]),
      .fall    (fall[g]),
      .cnt_we  (cnt_we[g]),
      .per_we  (per_we[g]),
      .wid_we  (wid_we[g]),
      .wdata   (bus_wdata),
      .cnt_q   (cnt_q[g]),
      .per_q   (per_q[g]),
      .wid_q   (wid_q[g]),
      .pin_o   (pin_o[g]),
      .pin_oe  (pin_oe[g]),
      .irq_q   (irq[g]),
      .ovf_evt (ovf_evt[g])
    );
  end

endmodule

// File: rtl/gpt_checker.sv
module gpt_checker
  import gpt_pkg::*;
#(
  parameter int N  = 3,
  parameter int CW = 32,
  parameter int AW = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 emu_halt,
  input logic                 bus_we,
  input logic [AW-1:0]        bus_addr,
  input logic [CW-1:0]        bus_wdata,
  input gpt_cfg_t [N-1:0]     cfg,
  input logic [N-1:0]         en,
  input logic [N-1:0][CW-1:0] cnt,
  input logic [N-1:0][CW-1:0] per,
  input logic [N-1:0]         ovf_evt,
  input logic [N-1:0]         ovf_st,
  input logic [N-1:0]         irq
);

  localparam logic [AW-1:0] CTRL_A = AW'(4 * N);

  for (genvar g = 0; g < N; g++) begin : g_chk
    assert_restart_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == CTRL_A && bus_wdata[g]) |=> (cnt[g] == '0));

    assert_wrap_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_we && en[g] && cfg[g].mode == GPT_PWM && cfg[g].irq_en &&
       (!emu_halt || cfg[g].emu_run) && cnt[g] == per[g]) |=> (irq[g] && cnt[g] == '0));

    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt[g] |=> ovf_st[g]);

    assert_halt_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_we && emu_halt && !cfg[g].emu_run) |=> $stable(cnt[g]));

    assert_stopped_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_we && !en[g]) |=> $stable(cnt[g]));
  end

endmodule

bind gp_timer_bank gpt_checker #(.N(N), .CW(CW), .AW(AW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .emu_halt  (emu_halt),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .cfg       (cfg_q),
  .en        (en_q),
  .cnt       (cnt_q),
  .per       (per_q),
  .ovf_evt   (ovf_evt),
  .ovf_st    (ovf_st),
  .irq       (irq)
);

// File: tb/gp_timer_bank_tb_top.sv
`timescale 1ns/1ps
module gp_timer_bank_tb_top;

  localparam int N    = 3;
  localparam int CW   = 32;
  localparam int AW   = 4;
  localparam int CTRL = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          emu_halt = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [CW-1:0] bus_wdata = '0;
  logic [CW-1:0] bus_rdata;
  logic [N-1:0]  pin_in = '0;
  logic [N-1:0]  pin_o, pin_oe, irq;

  int vectors = 0;
  int fails   = 0;
  bit go      = 1'b0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  gp_timer_bank #(.N(N), .CW(CW), .AW(AW)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .emu_halt  (emu_halt),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_i     (pin_in),
    .pin_o     (pin_o),
    .pin_oe    (pin_oe),
    .irq       (irq)
  );

  // ---------------- behavioural reference ----------------
  logic [31:0] m_cnt [N];
  logic [31:0] m_per [N];
  logic [31:0] m_wid [N];
  logic [5:0]  m_cfg [N];
  bit m_en [N], m_ovf [N], m_irq [N], m_armed [N];
  bit m_s1 [N], m_s2 [N], m_pv [N];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_cnt[i] = 0; m_per[i] = 0; m_wid[i] = 0; m_cfg[i] = 0;
        m_en[i] = 0; m_ovf[i] = 0; m_irq[i] = 0; m_armed[i] = 0;
        m_s1[i] = 0; m_s2[i] = 0; m_pv[i] = 0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        bit pol, rise, fall, run, ev, ov, na, ctl;
        logic [31:0] nc, np, nw, inc;
        int mode;
        pol  = m_cfg[i][2];
        mode = int'(m_cfg[i][1:0]);
        rise = ((m_s2[i] ^ pol) == 1'b1) && ((m_pv[i] ^ pol) == 1'b0);
        fall = ((m_s2[i] ^ pol) == 1'b0) && ((m_pv[i] ^ pol) == 1'b1);
        run  = m_en[i] && (!emu_halt || m_cfg[i][5]);
        nc = m_cnt[i]; np = m_per[i]; nw = m_wid[i]; na = m_armed[i];
        ev = 0; ov = 0;
        inc = m_cnt[i] + 32'd1;
        if (mode == 1 && run) begin
          if (m_cnt[i] == m_per[i]) begin nc = 0; ev = 1; end
          else nc = inc;
        end else if (mode == 2 && run) begin
          if (rise) begin
            if (m_armed[i]) begin np = inc; ev = m_cfg[i][4]; end
            nc = 0; na = 1;
          end else if (m_armed[i]) begin
            nc = inc;
            ov = (m_cnt[i] == 32'hFFFF_FFFF);
            if (fall) begin nw = inc; ev = !m_cfg[i][4]; end
          end
        end else if (mode == 3 && run && rise) begin
          ov = (m_cnt[i] == 32'hFFFF_FFFF);
          nc = (inc == m_per[i]) ? 32'd0 : inc;
          ev = (inc == m_per[i]);
        end
        ctl = bus_we && (int'(bus_addr) == CTRL);
        if (ctl && bus_wdata[i]) begin nc = 0; na = 0; end
        if (bus_we && int'(bus_addr) == 4*i + 1) nc = bus_wdata;
        if (bus_we && int'(bus_addr) == 4*i + 2) np = bus_wdata;
        if (bus_we && int'(bus_addr) == 4*i + 3) nw = bus_wdata;
        m_irq[i] = ev && m_cfg[i][3];
        m_ovf[i] = (m_ovf[i] && !(ctl && bus_wdata[16+i])) || ov;
        if (ctl) m_en[i] = (m_en[i] || bus_wdata[i]) && !bus_wdata[8+i];
        if (bus_we && int'(bus_addr) == 4*i) m_cfg[i] = bus_wdata[5:0];
        m_cnt[i] = nc; m_per[i] = np; m_wid[i] = nw; m_armed[i] = na;
        m_pv[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = pin_in[i];
      end
    end
  end

  function automatic logic [31:0] model_read(int a);
    logic [31:0] r;
    r = 0;
    if (a == CTRL) begin
      for (int i = 0; i < N; i++) begin
        r[i] = m_en[i];
        r[16+i] = m_ovf[i];
      end
    end else if (a < 4*N) begin
      case (a % 4)
        0: r = {26'd0, m_cfg[a/4]};
        1: r = m_cnt[a/4];
        2: r = m_per[a/4];
        default: r = m_wid[a/4];
      endcase
    end
    return r;
  endfunction

  function automatic string mode_tag(int i, bit is_irq);
    case (m_cfg[i][1:0])
      2'd1: return is_irq ? "R5" : "R4";
      2'd2: return is_irq ? "R7" : "R6";
      2'd3: return "R8";
      default: return "R11";
    endcase
  endfunction

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (go && !done) begin
      for (int i = 0; i < N; i++) begin
        bit exp_oe, exp_o;
        exp_oe = (m_cfg[i][1:0] == 2'd1);
        exp_o  = m_cfg[i][2] ^ (exp_oe && m_en[i] && (m_cnt[i] < m_wid[i]));
        vectors++;
        if (pin_oe[i] !== exp_oe || (exp_oe && pin_o[i] !== exp_o)) begin
          fails++;
          $display("FAIL %s timer%0d pin oe/o actual %b/%b expected %b/%b",
                   mode_tag(i, 0), i, pin_oe[i], pin_o[i], exp_oe, exp_o);
        end
        vectors++;
        if (irq[i] !== m_irq[i]) begin
          fails++;
          $display("FAIL %s timer%0d irq actual %b expected %b",
                   mode_tag(i, 1), i, irq[i], m_irq[i]);
        end
      end
    end
  end

  // ---------------- tasks ----------------
  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_check(int a, string req);
    logic [31:0] e;
    @(negedge clk);
    bus_addr = AW'(a);
    #1;
    e = model_read(a);
    vectors++;
    if (bus_rdata !== e) begin
      fails++;
      $display("FAIL %s addr %0d actual %h expected %h", req, a, bus_rdata, e);
    end
  endtask

  task automatic rd_const(int a, logic [31:0] e, string req);
    @(negedge clk);
    bus_addr = AW'(a);
    #1;
    vectors++;
    if (bus_rdata !== e) begin
      fails++;
      $display("FAIL %s addr %0d actual %h expected %h", req, a, bus_rdata, e);
    end
  endtask

  task automatic pulses(int i, int hi, int lo, int reps);
    for (int k = 0; k < reps; k++) begin
      @(negedge clk); pin_in[i] = 1'b1;
      repeat (hi - 1) @(negedge clk);
      @(negedge clk); pin_in[i] = 1'b0;
      repeat (lo - 1) @(negedge clk);
    end
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    go = 1'b1;

    // R1: reset state
    for (int a = 0; a <= CTRL; a++) rd_const(a, 32'd0, "R1");
    vectors++;
    if (pin_oe !== '0 || irq !== '0) begin
      fails++;
      $display("FAIL R1 oe/irq actual %b/%b expected 000/000", pin_oe, irq);
    end

    // R2: config layout and truncation
    wr(4, 32'hFFFF_FFFF);
    rd_const(4, 32'h0000_003F, "R2");
    wr(4, 32'h0);

    // R4 / R5 / R12: waveform on timer0
    wr(2, 32'd9);
    wr(3, 32'd3);
    rd_const(2, 32'd9, "R12");
    wr(0, 32'h09);
    wr(CTRL, 32'h1);
    repeat (40) @(negedge clk);
    rd_check(1, "R4");
    wr(0, 32'h0D);
    repeat (25) @(negedge clk);
    wr(1, 32'd5);
    rd_check(1, "R12");
    repeat (12) @(negedge clk);

    // R10: halt freezes, run-at-halt keeps counting
    emu_halt = 1'b1;
    rd_check(1, "R10");
    repeat (10) @(negedge clk);
    rd_check(1, "R10");
    wr(0, 32'h29);
    repeat (15) @(negedge clk);
    rd_check(1, "R10");
    emu_halt = 1'b0;

    // R11 / R3: stop timer0, count held
    wr(CTRL, 32'h100);
    rd_check(1, "R11");
    repeat (8) @(negedge clk);
    rd_check(1, "R11");
    rd_check(CTRL, "R3");

    // R6 / R7: capture on timer1, high 7, low 5
    wr(4, 32'h1A);
    wr(CTRL, 32'h2);
    pulses(1, 7, 5, 4);
    rd_const(6, 32'd12, "R6");
    rd_const(7, 32'd7, "R6");
    wr(4, 32'h0A);
    pulses(1, 7, 5, 3);
    rd_check(7, "R7");
    wr(4, 32'h0E);
    pulses(1, 7, 5, 4);
    rd_const(6, 32'd12, "R6");
    rd_const(7, 32'd5, "R6");

    // R8: event counting on timer2
    wr(10, 32'd4);
    wr(8, 32'h0B);
    wr(CTRL, 32'h4);
    pulses(2, 3, 3, 10);
    repeat (4) @(negedge clk);
    rd_check(9, "R8");
    rd_const(9, 32'd2, "R8");

    // R9: overflow in event mode, write-0 keeps, write-1 clears
    wr(9, 32'hFFFF_FFFF);
    wr(10, 32'd5);
    pulses(2, 3, 3, 1);
    repeat (4) @(negedge clk);
    rd_check(CTRL, "R9");
    rd_const(CTRL, 32'h0004_0006, "R9");
    wr(CTRL, 32'h0);
    rd_check(CTRL, "R9");
    wr(CTRL, 32'h0004_0000);
    rd_check(CTRL, "R9");

    // R9: overflow in capture mode
    pulses(1, 7, 5, 1);
    wr(5, 32'hFFFF_FFF8);
    repeat (12) @(negedge clk);
    rd_check(CTRL, "R9");

    // R3: start all at once, then stop all
    wr(CTRL, 32'h7);
    rd_check(1, "R3");
    rd_check(CTRL, "R3");
    repeat (20) @(negedge clk);
    wr(CTRL, 32'h700);
    rd_check(CTRL, "R3");
    repeat (5) @(negedge clk);

    summary();
  end

endmodule